// File: doc/BRIEF.md
# Prioritized Sixteen-Channel Interrupt Controller

This block gathers sixteen interrupt sources in a peripheral device and presents them to a host processor as a single active-high request line. Every channel has four state bits: an enable that decides whether events are accepted, a pending flag that records an accepted event, a mask that decides whether a pending flag may drive the request, and an in-service flag that marks an interrupt the host has taken but not yet finished. The host sees these bits as eight 8-bit registers. Each kind of state is split into a high bank for channels 15..8 and a low bank for channels 7..0.

A rising edge on an event input latches the pending flag of an enabled channel. Channel 15 has the highest fixed priority and channel 0 the lowest. While any channel is in service, only channels above the highest in-service channel may raise the request. When the host acknowledges, the block returns the 4-bit number of the winning channel one cycle later. It also clears that channel's pending flag and sets its in-service flag. The host clears pending and in-service flags by writing zeros. Writing ones to those registers changes nothing, so a host can also poll and clear the pending flags without using the acknowledge.

The channel sources are fixed. From 15 down to 8 they are: general input 7, general input 6, timer A, receive-buffer-full, receive error, transmit-buffer-empty, transmit error and timer B. From 7 down to 0 they are: general input 5, general input 4, timer C, timer D, then general inputs 3 down to 0. Event input bit n belongs to channel n.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every state bit is zero, every register reads 0x00, irq_o is low and ack_valid_o is low.
- R2: A rising edge on evt_i[n] of an enabled channel sets its pending bit at the next clock edge. A level held high sets it only once.
- R3: While a channel's enable bit is 0, events on that channel are ignored. Writing 0 to an enable bit clears that channel's pending bit and leaves its in-service bit unchanged.
- R4: Writing 0 to a pending register bit clears that bit. Writing 1 leaves the bit unchanged.
- R5: A pending bit with mask 0 still latches but does not drive irq_o. Setting the mask bit to 1 again lets the channel request again.
- R6: irq_o is high exactly when an eligible channel exists: pending, unmasked, and above every in-service channel. The winner is the highest-numbered eligible channel.
- R7: ack_i sampled high while irq_o is high causes, in the next cycle, ack_valid_o=1 and ack_id_o=winner. It also clears the winner's pending bit and sets its in-service bit. ack_i with irq_o low gives ack_valid_o=0.
- R8: While any in-service bit is set, only channels numbered strictly above the highest in-service channel can request.
- R9: Writing 0 to an in-service register bit clears it and writing 1 has no effect. In-service bits are set only by an acknowledge.
- R10: An event and a pending-clear write to the same channel in the same cycle leave the pending bit set.
- R11: Register addresses are 0 enable-high, 1 enable-low, 2 pending-high, 3 pending-low, 4 mask-high, 5 mask-low, 6 in-service-high and 7 in-service-low. In a high register, bit i is channel 8+i. In a low register, bit i is channel i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 16 | Event inputs, bit n drives channel n, rising edge active |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register select |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register, combinational |
| irq_o | output | 1 | Interrupt request, active high |
| ack_i | input | 1 | Acknowledge from host |
| ack_valid_o | output | 1 | Acknowledge response valid, one cycle |
| ack_id_o | output | 4 | Number of the acknowledged channel |

## Verification
The assertions assume that every input is a settled, known value at each rising clock edge. They do not assume that acknowledges are spaced apart or that writes avoid the acknowledge cycle. The bench changes every input only on the falling edge. It keeps all event inputs low across reset release, so the edge detector sees no false edge. It gives each acknowledge as a single-cycle pulse, so every response can be tied to one request.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int BANK_W = 8;
  localparam int NCH    = 2 * BANK_W;
  localparam int IDW    = $clog2(NCH);
  localparam int AW     = 3;

  typedef enum logic [AW-1:0] {
    REG_EN_HI   = 3'd0,
    REG_EN_LO   = 3'd1,
    REG_PEND_HI = 3'd2,
    REG_PEND_LO = 3'd3,
    REG_MASK_HI = 3'd4,
    REG_MASK_LO = 3'd5,
    REG_ISV_HI  = 3'd6,
    REG_ISV_LO  = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic [NCH-1:0] en;
    logic [NCH-1:0] pend;
    logic [NCH-1:0] mask;
    logic [NCH-1:0] isv;
  } chan_we_t;
endpackage

// File: rtl/irq_regif.sv
module irq_regif
  import irq_pkg::*;
#(
  parameter int BW = BANK_W,
  localparam int N = 2 * BW
) (
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [BW-1:0] wdata_i,
  input  logic [N-1:0]  en_i,
  input  logic [N-1:0]  pend_i,
  input  logic [N-1:0]  mask_i,
  input  logic [N-1:0]  isv_i,
  output chan_we_t      we_o,
  output logic [N-1:0]  wd_o,
  output logic [BW-1:0] rdata_o
);
  reg_sel_e      sel;
  logic [N-1:0]  bank_sel;

  assign sel  = reg_sel_e'(addr_i);
  assign wd_o = {wdata_i, wdata_i};
  // even addresses select the high bank
  assign bank_sel = addr_i[0] ? {{BW{1'b0}}, {BW{1'b1}}} : {{BW{1'b1}}, {BW{1'b0}}};

  always_comb begin
    we_o = '0;
    if (wr_i) begin
      unique case (addr_i[AW-1:1])
        2'd0: we_o.en   = bank_sel;
        2'd1: we_o.pend = bank_sel;
        2'd2: we_o.mask = bank_sel;
        default: we_o.isv = bank_sel;
      endcase
    end
  end

  always_comb begin
    unique case (sel)
      REG_EN_HI:   rdata_o = en_i[N-1:BW];
      REG_EN_LO:   rdata_o = en_i[BW-1:0];
      REG_PEND_HI: rdata_o = pend_i[N-1:BW];
      REG_PEND_LO: rdata_o = pend_i[BW-1:0];
      REG_MASK_HI: rdata_o = mask_i[N-1:BW];
      REG_MASK_LO: rdata_o = mask_i[BW-1:0];
      REG_ISV_HI:  rdata_o = isv_i[N-1:BW];
      default:     rdata_o = isv_i[BW-1:0];
    endcase
  end
endmodule

// File: rtl/irq_chan_bank.sv
module irq_chan_bank
  import irq_pkg::*;
#(
  parameter int N = NCH
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] rise_i,
  input  logic [N-1:0] ack_hit_i,
  input  chan_we_t     we_i,
  input  logic [N-1:0] wd_i,
  output logic [N-1:0] en_o,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] mask_o,
  output logic [N-1:0] isv_o
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    logic en_q, pend_q, mask_q, isv_q;
    logic en_n, pend_n, mask_n, isv_n;

    always_comb begin
      en_n   = we_i.en[i]   ? wd_i[i] : en_q;
      mask_n = we_i.mask[i] ? wd_i[i] : mask_q;
      pend_n = pend_q & ~(we_i.pend[i] & ~wd_i[i]) & ~ack_hit_i[i];
      // event wins over any clear; disabling kills everything
      pend_n = (pend_n | (rise_i[i] & en_q)) & en_n;
      isv_n  = (isv_q & ~(we_i.isv[i] & ~wd_i[i])) | ack_hit_i[i];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q   <= 1'b0;
        pend_q <= 1'b0;
        mask_q <= 1'b0;
        isv_q  <= 1'b0;
      end else begin
        en_q   <= en_n;
        pend_q <= pend_n;
        mask_q <= mask_n;
        isv_q  <= isv_n;
      end
    end

    assign en_o[i]   = en_q;
    assign pend_o[i] = pend_q;
    assign mask_o[i] = mask_q;
    assign isv_o[i]  = isv_q;
  end
endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve
  import irq_pkg::*;
#(
  parameter int N = NCH,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] isv_i,
  output logic         req_o,
  output logic [W-1:0] win_o,
  output logic [N-1:0] win_oh_o
);
  logic [N-1:0] above, elig;

  // channel i may request only if nothing at or above i is in service
  for (genvar i = 0; i < N; i++) begin : g_above
    assign above[i] = ~|isv_i[N-1:i];
  end

  assign elig  = pend_i & mask_i & above;
  assign req_o = |elig;

  always_comb begin
    win_o = '0;
    for (int i = 0; i < N; i++) begin
      if (elig[i]) win_o = W'(i);
    end
  end

  always_comb begin
    win_oh_o = '0;
    win_oh_o[win_o] = req_o;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH-1:0]    evt_i,
  input  logic              wr_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [BANK_W-1:0] rdata_o,
  output logic              irq_o,
  input  logic              ack_i,
  output logic              ack_valid_o,
  output logic [IDW-1:0]    ack_id_o
);
  logic [NCH-1:0] evt_q, rise;
  logic [NCH-1:0] en_q, pend_q, mask_q, isv_q;
  logic [NCH-1:0] wd, win_oh, ack_hit;
  logic [IDW-1:0] win;
  logic           req;
  chan_we_t       we;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else         evt_q <= evt_i;
  end
  assign rise = evt_i & ~evt_q;

  irq_regif #(.BW(BANK_W)) u_regif (
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .en_i    (en_q),
    .pend_i  (pend_q),
    .mask_i  (mask_q),
    .isv_i   (isv_q),
    .we_o    (we),
    .wd_o    (wd),
    .rdata_o (rdata_o)
  );

  irq_prio_resolve #(.N(NCH)) u_prio (
    .pend_i   (pend_q),
    .mask_i   (mask_q),
    .isv_i    (isv_q),
    .req_o    (req),
    .win_o    (win),
    .win_oh_o (win_oh)
  );

  assign ack_hit = ack_i ? win_oh : '0;

  irq_chan_bank #(.N(NCH)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (rise),
    .ack_hit_i (ack_hit),
    .we_i      (we),
    .wd_i      (wd),
    .en_o      (en_q),
    .pend_o    (pend_q),
    .mask_o    (mask_q),
    .isv_o     (isv_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_valid_o <= 1'b0;
      ack_id_o    <= '0;
    end else begin
      ack_valid_o <= ack_i & req;
      if (ack_i & req) ack_id_o <= win;
    end
  end

  assign irq_o = req;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
  import irq_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic           ack_i,
  input logic           irq_o,
  input logic           ack_valid_o,
  input logic [IDW-1:0] ack_id_o,
  input logic [NCH-1:0] en_q,
  input logic [NCH-1:0] pend_q,
  input logic [NCH-1:0] mask_q,
  input logic [NCH-1:0] isv_q
);
  a_r3_no_pend_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q & ~en_q) == '0);

  a_r5_irq_needs_unmasked_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |(pend_q & mask_q));

  a_r7_ack_follows_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_o |-> ($past(ack_i) && $past(irq_o)));

  a_r8_acked_is_top_in_service: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_o |-> ((isv_q >> ack_id_o) == NCH'(1)));

  a_r9_isv_set_only_by_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> ((isv_q & ~$past(isv_q)) == '0));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ack_i       (ack_i),
  .irq_o       (irq_o),
  .ack_valid_o (ack_valid_o),
  .ack_id_o    (ack_id_o),
  .en_q        (en_q),
  .pend_q      (pend_q),
  .mask_q      (mask_q),
  .isv_q       (isv_q)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] evt_i = '0;
  logic        wr_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        irq_o;
  logic        ack_i = 1'b0;
  logic        ack_valid_o;
  logic [3:0]  ack_id_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk_i = ~clk_i;

  prio_irq_ctrl u_prio_irq_ctrl (.*);

  localparam logic [2:0] A_EN_HI = 3'd0, A_EN_LO = 3'd1, A_PD_HI = 3'd2, A_PD_LO = 3'd3,
                         A_MK_HI = 3'd4, A_MK_LO = 3'd5, A_IS_HI = 3'd6, A_IS_LO = 3'd7;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    addr_i = a;
    #1;
    chk(req, rdata_o, exp);
  endtask

  task automatic pulse(input logic [15:0] bits);
    @(negedge clk_i);
    evt_i = evt_i | bits;
    @(negedge clk_i);
    evt_i = evt_i & ~bits;
  endtask

  task automatic ack_chk(input string req, input logic vexp, input logic [3:0] iexp);
    @(negedge clk_i);
    ack_i = 1'b1;
    @(negedge clk_i);
    ack_i = 1'b0;
    chk(req, ack_valid_o, vexp);
    if (vexp) chk(req, ack_id_o, iexp);
  endtask

  task automatic t_reset();
    for (int a = 0; a < 8; a++) rd_chk("R1", 3'(a), 8'h00);
    chk("R1", irq_o, 0);
    chk("R1", ack_valid_o, 0);
  endtask

  task automatic t_edge();
    wr(A_EN_HI, 8'hFF); wr(A_EN_LO, 8'hFF);
    wr(A_MK_HI, 8'hFF); wr(A_MK_LO, 8'hFF);
    pulse(16'h0008);
    rd_chk("R2", A_PD_LO, 8'h08);
    chk("R2", irq_o, 1);
    @(negedge clk_i); evt_i[5] = 1'b1;
    @(negedge clk_i);
    rd_chk("R11", A_PD_LO, 8'h28);
    wr(A_PD_LO, 8'hDF);
    repeat (2) @(negedge clk_i);
    rd_chk("R2", A_PD_LO, 8'h08);
    evt_i[5] = 1'b0;
    wr(A_PD_LO, 8'h00);
    chk("R6", irq_o, 0);
  endtask

  task automatic t_pend_write();
    pulse(16'h0600);
    rd_chk("R11", A_PD_HI, 8'h06);
    wr(A_PD_HI, 8'hFF);
    rd_chk("R4", A_PD_HI, 8'h06);
    wr(A_PD_HI, 8'hFB);
    rd_chk("R4", A_PD_HI, 8'h02);
    wr(A_PD_HI, 8'h00);
    rd_chk("R4", A_PD_HI, 8'h00);
  endtask

  task automatic t_mask();
    wr(A_MK_LO, 8'hFE);
    pulse(16'h0001);
    rd_chk("R5", A_PD_LO, 8'h01);
    chk("R5", irq_o, 0);
    wr(A_MK_LO, 8'hFF);
    chk("R5", irq_o, 1);
    wr(A_PD_LO, 8'h00);
    chk("R6", irq_o, 0);
  endtask

  task automatic t_enable();
    wr(A_EN_LO, 8'hEF);
    pulse(16'h0010);
    rd_chk("R3", A_PD_LO, 8'h00);
    chk("R3", irq_o, 0);
    wr(A_EN_LO, 8'hFF);
    pulse(16'h0010);
    ack_chk("R7", 1'b1, 4'd4);
    rd_chk("R7", A_IS_LO, 8'h10);
    rd_chk("R7", A_PD_LO, 8'h00);
    pulse(16'h0010);
    rd_chk("R3", A_PD_LO, 8'h10);
    wr(A_EN_LO, 8'hEF);
    rd_chk("R3", A_PD_LO, 8'h00);
    rd_chk("R3", A_IS_LO, 8'h10);
    wr(A_IS_LO, 8'hFF);
    rd_chk("R9", A_IS_LO, 8'h10);
    wr(A_IS_LO, 8'hEF);
    rd_chk("R9", A_IS_LO, 8'h00);
    wr(A_EN_LO, 8'hFF);
  endtask

  task automatic t_prio_ack();
    pulse(16'h1084);
    chk("R6", irq_o, 1);
    ack_chk("R6", 1'b1, 4'd12);
    rd_chk("R7", A_PD_HI, 8'h00);
    rd_chk("R7", A_IS_HI, 8'h10);
    chk("R8", irq_o, 0);
    pulse(16'h4000);
    chk("R8", irq_o, 1);
    ack_chk("R8", 1'b1, 4'd14);
    rd_chk("R8", A_IS_HI, 8'h50);
    wr(A_IS_HI, 8'hBF);
    rd_chk("R9", A_IS_HI, 8'h10);
    chk("R8", irq_o, 0);
    wr(A_IS_HI, 8'hEF);
    chk("R8", irq_o, 1);
    ack_chk("R6", 1'b1, 4'd7);
    wr(A_IS_LO, 8'h7F);
    ack_chk("R6", 1'b1, 4'd2);
    wr(A_IS_LO, 8'h00);
    chk("R6", irq_o, 0);
    ack_chk("R7", 1'b0, 4'd0);
    rd_chk("R9", A_IS_LO, 8'h00);
  endtask

  task automatic t_collide();
    @(negedge clk_i);
    evt_i[1] = 1'b1; wr_i = 1'b1; addr_i = A_PD_LO; wdata_i = 8'h00;
    @(negedge clk_i);
    evt_i[1] = 1'b0; wr_i = 1'b0;
    rd_chk("R10", A_PD_LO, 8'h02);
    wr(A_PD_LO, 8'h00);
    rd_chk("R10", A_PD_LO, 8'h00);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_edge();
    t_pend_write();
    t_mask();
    t_enable();
    t_prio_ack();
    t_collide();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule